// File: doc/BRIEF.md
# Block-Skip Significand Adder/Subtractor

This block is a purely combinational adder/subtractor for the significand datapath of a floating-point unit. It takes two unsigned operands of a parameterised width and an operation select. It returns the sum or the difference, together with the carry out of the top bit. Subtraction is done in two's complement: the second operand is inverted bit by bit, and the carry into the lowest bit is set to one.

The word is split into groups of four bits. Inside each group, four full adders ripple a carry from the lowest bit to the highest. Each full adder reports whether its bit would pass a carry straight through. The AND of these four propagate bits forms the group propagate. When the group propagate is high, a per-group multiplexer hands the group's incoming carry directly to the next group. This way the carry does not wait for the ripple inside the group. When the group propagate is low, the rippled carry is used instead. The sum bits always come from the ripple chain. The operand width must be a multiple of four.

Top module: `csa_adder`

## Requirements
- R1: With `sub_i` = 0, the concatenation {`cout_o`, `sum_o`} equals the unsigned sum `a_i` + `b_i` computed at WIDTH+1 bits.
- R2: With `sub_i` = 1, `sum_o` equals (`a_i` - `b_i`) modulo 2^WIDTH.
- R3: With `sub_i` = 1, `cout_o` is 1 exactly when `a_i` >= `b_i` taken as unsigned values (no borrow).
- R4: When a group's propagate is 1, the carry leaving that group equals the carry entering it. In particular, when every bit of `a_i` XOR the effective second operand is 1, the outputs are as follows. In add mode, `sum_o` is all ones and `cout_o` = 0. In subtract mode, `sum_o` is 0 and `cout_o` = 1.
- R5: When a group's propagate is 0, the carry leaving that group equals the carry rippled out of its top full adder. For example, a carry generated in the low group (0x0F + 0x01) reaches the next group.
- R6: A group's propagate is the AND of its four bit propagates. Each bit propagate is `a_i`[i] XOR the effective second-operand bit, where the effective bit is `b_i`[i] XOR `sub_i`.
- R7: The carry into the lowest group equals `sub_i`. As a result, 0 - 1 gives `sum_o` all ones with `cout_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend in subtract mode) |
| b_i | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| sum_o | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| cout_o | output | 1 | Carry out of the top bit (1 = no borrow when subtracting) |

## Verification
The bench builds the adder with WIDTH = 8, which gives two groups and one skip multiplexer between them, plus the skip at the top. At this width, every operand pair in both modes (131,072 vectors) can be applied within the cycle budget. The sweep therefore reaches every combination of skipped and rippled carry at each group boundary, including the full-skip chains in which a carry-in passes through both groups untouched. Directed vectors then confirm a generated carry crossing a group boundary, a partial-propagate group, and the 0 - 1 wrap.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Bits per ripple group; fixed by the architecture.
  localparam int unsigned CSA_GRP = 4;

  function automatic int unsigned csa_groups(input int unsigned width);
    return width / CSA_GRP;
  endfunction

endpackage

// File: rtl/csa_operand_prep.sv
module csa_operand_prep #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] b_eff_o
);

  // Conditional one's complement of the second operand.
  always_comb begin
    b_eff_o = b_i ^ {WIDTH{sub_i}};
  end

endmodule

// File: rtl/csa_full_adder.sv
module csa_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o,
  output logic p_o
);

  logic prop;
  logic gen;

  always_comb begin
    prop = a_i ^ b_i;
    gen  = a_i & b_i;
    s_o  = prop ^ ci_i;
    co_o = gen | (prop & ci_i);
    p_o  = prop;
  end

endmodule

// File: rtl/csa_ripple_group.sv
module csa_ripple_group
  import csa_pkg::*;
(
  input  logic [CSA_GRP-1:0] a_i,
  input  logic [CSA_GRP-1:0] b_i,
  input  logic               ci_i,
  output logic [CSA_GRP-1:0] s_o,
  output logic               co_ripple_o,
  output logic               grp_p_o
);

  logic [CSA_GRP-1:0] bit_p;

  for (genvar i = 0; i < CSA_GRP; i++) begin : g_fa
    logic c_in;
    logic c_out;
    if (i == 0) begin : g_first
      assign c_in = ci_i;
    end else begin : g_next
      assign c_in = g_fa[i-1].c_out;
    end
    csa_full_adder u_fa (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .ci_i (c_in),
      .s_o  (s_o[i]),
      .co_o (c_out),
      .p_o  (bit_p[i])
    );
  end

  assign co_ripple_o = g_fa[CSA_GRP-1].c_out;
  assign grp_p_o     = &bit_p;

endmodule

// File: rtl/csa_skip_mux.sv
module csa_skip_mux (
  input  logic ci_i,
  input  logic co_ripple_i,
  input  logic grp_p_i,
  output logic co_o
);

  // Full propagate: the group can neither generate nor kill, so bypass it.
  always_comb begin
    co_o = grp_p_i ? ci_i : co_ripple_i;
  end

endmodule

// File: rtl/csa_adder.sv
module csa_adder
  import csa_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int unsigned NGRP = csa_groups(WIDTH);

  logic [WIDTH-1:0] b_eff;
  logic [NGRP-1:0]  grp_cin;
  logic [NGRP-1:0]  grp_cout;
  logic [NGRP-1:0]  grp_ripple;
  logic [NGRP-1:0]  grp_prop;

  csa_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .b_i     (b_i),
    .sub_i   (sub_i),
    .b_eff_o (b_eff)
  );

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    logic c_in;
    logic c_rip;
    logic c_out;
    logic p_grp;
    if (k == 0) begin : g_lsb
      assign c_in = sub_i;
    end else begin : g_chain
      assign c_in = g_grp[k-1].c_out;
    end

    csa_ripple_group u_grp (
      .a_i         (a_i[k*CSA_GRP +: CSA_GRP]),
      .b_i         (b_eff[k*CSA_GRP +: CSA_GRP]),
      .ci_i        (c_in),
      .s_o         (sum_o[k*CSA_GRP +: CSA_GRP]),
      .co_ripple_o (c_rip),
      .grp_p_o     (p_grp)
    );

    csa_skip_mux u_skip (
      .ci_i        (c_in),
      .co_ripple_i (c_rip),
      .grp_p_i     (p_grp),
      .co_o        (c_out)
    );

    assign grp_cin[k]    = c_in;
    assign grp_cout[k]   = c_out;
    assign grp_ripple[k] = c_rip;
    assign grp_prop[k]   = p_grp;
  end

  assign cout_o = g_grp[NGRP-1].c_out;

endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk
  import csa_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0]              a_i,
  input logic [WIDTH-1:0]              b_i,
  input logic                          sub_i,
  input logic [WIDTH-1:0]              sum_o,
  input logic                          cout_o,
  input logic [csa_groups(WIDTH)-1:0]  grp_cin,
  input logic [csa_groups(WIDTH)-1:0]  grp_cout,
  input logic [csa_groups(WIDTH)-1:0]  grp_ripple,
  input logic [csa_groups(WIDTH)-1:0]  grp_prop
);

  localparam int unsigned NGRP = csa_groups(WIDTH);

  logic [WIDTH:0] ref_add;
  logic [WIDTH-1:0] ref_sub;
  logic [WIDTH-1:0] b_cmp;

  always_comb begin
    ref_add = {1'b0, a_i} + {1'b0, b_i};
    ref_sub = a_i - b_i;
    b_cmp   = b_i ^ {WIDTH{sub_i}};
    if (!$isunknown({a_i, b_i, sub_i})) begin
      if (!sub_i) begin
        AST_ADD_RESULT: assert ({cout_o, sum_o} == ref_add) else $error("add mismatch"); // R1
      end else begin
        AST_SUB_RESULT: assert (sum_o == ref_sub) else $error("sub mismatch"); // R2
        AST_SUB_NO_BORROW: assert (cout_o == (a_i >= b_i)) else $error("borrow mismatch"); // R3
      end
      AST_CARRY_IN: assert (grp_cin[0] == sub_i) else $error("carry-in mismatch"); // R7
      for (int k = 0; k < NGRP; k++) begin
        if (grp_prop[k]) begin
          AST_SKIP_PASS: assert (grp_cout[k] == grp_cin[k]) else $error("skip mismatch"); // R4
        end else begin
          AST_RIPPLE_PASS: assert (grp_cout[k] == grp_ripple[k]) else $error("ripple mismatch"); // R5
        end
        AST_GROUP_PROP: assert (grp_prop[k] == &(a_i[k*CSA_GRP +: CSA_GRP] ^ b_cmp[k*CSA_GRP +: CSA_GRP]))
          else $error("group propagate mismatch"); // R6
      end
    end
  end

endmodule

bind csa_adder csa_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .sub_i      (sub_i),
  .sum_o      (sum_o),
  .cout_o     (cout_o),
  .grp_cin    (grp_cin),
  .grp_cout   (grp_cout),
  .grp_ripple (grp_ripple),
  .grp_prop   (grp_prop)
);

// File: tb/tb_csa_adder.sv
module tb_csa_adder;

  localparam int unsigned W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         sub;
  logic [W-1:0] sum;
  logic         cout;

  int unsigned n_checks;
  int unsigned n_errors;
  int unsigned cycles;
  bit          done;

  csa_adder #(.WIDTH(W)) dut (
    .a_i    (a),
    .b_i    (b),
    .sub_i  (sub),
    .sum_o  (sum),
    .cout_o (cout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input int unsigned got, input int unsigned exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s a=%0h b=%0h sub=%0b actual=%0h expected=%0h", tag, a, b, sub, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  task automatic apply(input int unsigned av, input int unsigned bv, input bit sv);
    @(posedge clk);
    a   = W'(av);
    b   = W'(bv);
    sub = sv;
    @(negedge clk);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 180000) begin
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected<180000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    a        = '0;
    b        = '0;
    sub      = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Idle state with zero operands: R1
    check("R1 idle sum", sum, 0);
    check("R1 idle cout", cout, 0);
    rst_n = 1'b1;

    // Exhaustive sweep over both modes.
    for (int s = 0; s < 2; s++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          apply(x, y, s[0]);
          if (s == 0) begin
            check("R1", {cout, sum}, x + y);
            if ((x ^ y) == 255) begin
              // Full-skip chain in add mode: R4
              check("R4 add all-propagate", {cout, sum}, 255);
            end
          end else begin
            check("R2", sum, (x - y + 256) % 256);
            check("R3", cout, (x >= y) ? 1 : 0);
            if (x == y) begin
              // Full-skip chain in subtract mode: R4
              check("R4 sub all-propagate", {cout, sum}, 256);
            end
          end
        end
      end
    end

    // Generated carry crossing the group boundary: R5
    apply(8'h0F, 8'h01, 1'b0);
    check("R5 generate crosses", {cout, sum}, 9'h010);
    // Low group fully propagating, upper group mixed: R6
    apply(8'h37, 8'h48, 1'b0);
    check("R6 partial propagate", {cout, sum}, 9'h07F);
    apply(8'h37, 8'h48, 1'b1);
    check("R6 sub partial", {cout, sum}, 9'h0EF);
    // Wrap below zero, carry-in of one: R7
    apply(8'h00, 8'h01, 1'b1);
    check("R7 zero minus one", {cout, sum}, 9'h0FF);
    apply(8'h00, 8'h00, 1'b1);
    check("R7 zero minus zero", {cout, sum}, 9'h100);

    finish_run();
  end

endmodule